// File: doc/BRIEF.md
# Byte-to-Word Data Port Packer

This block bridges a transfer engine that moves one byte per handshake and a data FIFO whose port is one 32-bit word wide. A transfer begins with a one-cycle start strobe that carries the direction and a 12-bit byte count. In the write direction, incoming bytes are collected into a word register, with the first byte in the lowest lane. Each completed word goes to the FIFO as soon as the FIFO has room. Any final word that holds only 1 to 3 bytes is pushed with its unused upper lanes cleared to zero.

In the read direction, the block pops a word when the FIFO has one and then hands its lanes to the byte consumer, lowest lane first. The remaining lanes are kept across consumer stalls. Lanes past the end of the byte count are dropped. A one-cycle done strobe marks the end of every transfer. A write finishes once its last word has left; a read finishes once its last byte has been taken. Lane count, lane width and count width are parameters.

Top module: `bytepack_port`

## Requirements
- R1: After reset the block is idle: `in_ready_o`, `out_valid_o`, `push_o`, `pop_o` and `done_o` are all low, whatever the inputs do.
- R2: In write mode, byte k of a transfer lands in word k/4 at bits [8*(k%4)+7 : 8*(k%4)], so the first byte of each word sits in bits [7:0].
- R3: A word is pushed only in a cycle where `fifo_full_i` is low. While a complete word waits on a full FIFO, no further byte is accepted, and no byte is lost or duplicated.
- R4: When the byte count ends part-way through a word, that word is pushed once, with every lane past the last byte equal to zero. Exactly ceil(count/4) words are pushed per write.
- R5: In read mode, a word is popped only in a cycle where `fifo_empty_i` is low. Its lanes are emitted from bits [7:0] upward. A stalled byte stays valid and unchanged until it is taken.
- R6: In read mode, exactly ceil(count/4) words are popped. Lanes of the last word beyond the byte count are discarded and never presented.
- R7: `done_o` is high for exactly one cycle per transfer. It comes after the last byte has been accepted and its word pushed (write), or after the last byte has been taken (read). A count of zero completes with no data movement.
- R8: A start strobe clears the lane position and the held word, even in the middle of a transfer. Bytes from an abandoned transfer never appear in the new one.
- R9: The direction is sampled only at the start strobe. Changes on `dir_rd_i` during a transfer have no effect.
- R10: Only the port of the active direction moves. In write mode `pop_o` and `out_valid_o` stay low, and in read mode `push_o` and `in_ready_o` stay low. Once idle, nothing moves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a transfer; samples direction and count |
| dir_rd_i | input | 1 | 1 = read (FIFO to bytes), 0 = write (bytes to FIFO) |
| len_i | input | 12 | Transfer length in bytes |
| in_valid_i | input | 1 | Write byte valid |
| in_data_i | input | 8 | Write byte |
| in_ready_o | output | 1 | Write byte accepted this cycle when valid |
| out_valid_o | output | 1 | Read byte valid |
| out_data_o | output | 8 | Read byte |
| out_ready_i | input | 1 | Read byte taken this cycle when valid |
| push_o | output | 1 | Push strobe to FIFO |
| push_data_o | output | 32 | Word pushed |
| fifo_full_i | input | 1 | FIFO cannot take a word |
| pop_o | output | 1 | Pop strobe to FIFO |
| pop_data_i | input | 32 | Head word of FIFO, valid while not empty |
| fifo_empty_i | input | 1 | FIFO holds no word |
| done_o | output | 1 | One-cycle end-of-transfer strobe |

## Verification
The assertions check, on every cycle, the handshake rules at the FIFO side: no push into a full FIFO and no pop from an empty one. They also check that a stalled output byte holds, that the two directions never move together, and that the done strobe is one cycle long with the block quiet while it is high. The arithmetic content of the data can only be shown by the bench's sweeps over lengths and stall patterns. That content covers lane placement, zero padding of the tail, the number of words moved, dropping of surplus lanes, restart clearing and direction latching.

// File: rtl/bytepack_pkg.sv
package bytepack_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_WR   = 2'd1,
    MODE_RD   = 2'd2
  } mode_e;
endpackage

// File: rtl/bytepack_wr.sv
module bytepack_wr #(
  parameter int BW    = 8,
  parameter int LANES = 4,
  localparam int WW   = BW * LANES,
  localparam int PW   = $clog2(LANES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          en_i,
  input  logic          more_i,
  input  logic          in_valid_i,
  input  logic [BW-1:0] in_data_i,
  output logic          in_ready_o,
  input  logic          fifo_full_i,
  output logic          push_o,
  output logic [WW-1:0] push_data_o,
  output logic          fire_o,
  output logic          drained_o
);
  logic [WW-1:0] word_q, word_n;
  logic [PW-1:0] pos_q, pos_n;
  logic          have_full, have_tail;

  assign have_full   = (pos_q == PW'(LANES));
  assign have_tail   = !more_i && (pos_q != '0);
  assign push_o      = en_i && (have_full || have_tail) && !fifo_full_i;
  assign push_data_o = word_q;
  assign in_ready_o  = en_i && more_i && (!have_full || push_o);
  assign fire_o      = in_valid_i && in_ready_o;

  always_comb begin
    word_n = word_q;
    pos_n  = pos_q;
    if (push_o) begin
      word_n = '0;
      pos_n  = '0;
    end
    if (fire_o) begin
      for (int i = 0; i < LANES; i++) begin
        if (pos_n == PW'(i)) word_n[i*BW +: BW] = in_data_i;
      end
      pos_n = pos_n + PW'(1);
    end
  end

  assign drained_o = (pos_n == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      pos_q  <= '0;
    end else if (clr_i) begin
      word_q <= '0;
      pos_q  <= '0;
    end else if (en_i) begin
      word_q <= word_n;
      pos_q  <= pos_n;
    end
  end
endmodule

// File: rtl/bytepack_rd.sv
module bytepack_rd #(
  parameter int BW    = 8,
  parameter int LANES = 4,
  localparam int WW   = BW * LANES,
  localparam int PW   = $clog2(LANES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          en_i,
  input  logic          more_i,
  input  logic          beyond_i,
  output logic          out_valid_o,
  output logic [BW-1:0] out_data_o,
  input  logic          out_ready_i,
  input  logic          fifo_empty_i,
  output logic          pop_o,
  input  logic [WW-1:0] pop_data_i,
  output logic          fire_o
);
  logic [WW-1:0] word_q, word_n;
  logic [PW-1:0] left_q, left_n;
  logic          holding;

  assign holding     = (left_q != '0);
  assign out_valid_o = en_i && more_i && holding;
  assign out_data_o  = word_q[BW-1:0];
  assign fire_o      = out_valid_o && out_ready_i;
  assign pop_o       = en_i && !fifo_empty_i &&
                       ((more_i && !holding) ||
                        (fire_o && left_q == PW'(1) && beyond_i));

  always_comb begin
    word_n = word_q;
    left_n = left_q;
    if (fire_o) begin
      word_n = word_q >> BW;
      left_n = left_q - PW'(1);
    end
    if (pop_o) begin
      word_n = pop_data_i;
      left_n = PW'(LANES);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      left_q <= '0;
    end else if (clr_i) begin
      word_q <= '0;
      left_q <= '0;
    end else if (en_i) begin
      word_q <= word_n;
      left_q <= left_n;
    end
  end
endmodule

// File: rtl/bytepack_port.sv
module bytepack_port
  import bytepack_pkg::*;
#(
  parameter int BW    = 8,
  parameter int LANES = 4,
  parameter int LEN_W = 12,
  localparam int WW   = BW * LANES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             dir_rd_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             in_valid_i,
  input  logic [BW-1:0]    in_data_i,
  output logic             in_ready_o,
  output logic             out_valid_o,
  output logic [BW-1:0]    out_data_o,
  input  logic             out_ready_i,
  output logic             push_o,
  output logic [WW-1:0]    push_data_o,
  input  logic             fifo_full_i,
  output logic             pop_o,
  input  logic [WW-1:0]    pop_data_i,
  input  logic             fifo_empty_i,
  output logic             done_o
);
  mode_e            mode_q, mode_n;
  logic [LEN_W-1:0] rem_q, rem_n;
  logic             done_q, done_n;
  logic             more, beyond;
  logic             wr_fire, rd_fire, wr_drained;

  assign more   = (rem_q != '0);
  assign beyond = (rem_q > LEN_W'(1));

  bytepack_wr #(.BW(BW), .LANES(LANES)) u_wr (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (start_i),
    .en_i       (mode_q == MODE_WR),
    .more_i     (more),
    .in_valid_i (in_valid_i),
    .in_data_i  (in_data_i),
    .in_ready_o (in_ready_o),
    .fifo_full_i(fifo_full_i),
    .push_o     (push_o),
    .push_data_o(push_data_o),
    .fire_o     (wr_fire),
    .drained_o  (wr_drained)
  );

  bytepack_rd #(.BW(BW), .LANES(LANES)) u_rd (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_i       (start_i),
    .en_i        (mode_q == MODE_RD),
    .more_i      (more),
    .beyond_i    (beyond),
    .out_valid_o (out_valid_o),
    .out_data_o  (out_data_o),
    .out_ready_i (out_ready_i),
    .fifo_empty_i(fifo_empty_i),
    .pop_o       (pop_o),
    .pop_data_i  (pop_data_i),
    .fire_o      (rd_fire)
  );

  always_comb begin
    mode_n = mode_q;
    rem_n  = rem_q - LEN_W'(wr_fire || rd_fire);
    done_n = 1'b0;
    if (start_i) begin
      mode_n = dir_rd_i ? MODE_RD : MODE_WR;
      rem_n  = len_i;
    end else if (mode_q != MODE_IDLE && rem_n == '0 &&
                 (mode_q == MODE_RD || wr_drained)) begin
      mode_n = MODE_IDLE;
      done_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_IDLE;
      rem_q  <= '0;
      done_q <= 1'b0;
    end else begin
      mode_q <= mode_n;
      rem_q  <= rem_n;
      done_q <= done_n;
    end
  end

  assign done_o = done_q;
endmodule

// File: rtl/bytepack_port_chk.sv
module bytepack_port_chk #(
  parameter int BW = 8,
  parameter int WW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          in_ready_o,
  input logic          out_valid_o,
  input logic [BW-1:0] out_data_o,
  input logic          out_ready_i,
  input logic          push_o,
  input logic          fifo_full_i,
  input logic          pop_o,
  input logic          fifo_empty_i,
  input logic          done_o
);
  // R3
  push_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_o |-> !fifo_full_i);
  // R5
  pop_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_o |-> !fifo_empty_i);
  // R5
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i && !start_i) |=> (out_valid_o && $stable(out_data_o)));
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R7
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !(in_ready_o || out_valid_o || push_o || pop_o));
  // R10
  one_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !((in_ready_o || push_o) && (out_valid_o || pop_o)));
endmodule

bind bytepack_port bytepack_port_chk #(.BW(BW), .WW(WW)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .out_data_o  (out_data_o),
  .out_ready_i (out_ready_i),
  .push_o      (push_o),
  .fifo_full_i (fifo_full_i),
  .pop_o       (pop_o),
  .fifo_empty_i(fifo_empty_i),
  .done_o      (done_o)
);

// File: tb/test_bytepack_port.sv
module test_bytepack_port;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i, dir_rd_i, in_valid_i, out_ready_i, fifo_full_i, fifo_empty_i;
  logic [11:0] len_i;
  logic [7:0]  in_data_i, out_data_o;
  logic        in_ready_o, out_valid_o, push_o, pop_o, done_o;
  logic [31:0] push_data_o, pop_data_i;
  int errors = 0;
  int checks = 0;
  bit ended  = 0;

  always #4 clk = ~clk;

  bytepack_port i_bytepack_port (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] bv(int n, int i);
    return 8'((n * 37 + i * 11 + 5) & 255);
  endfunction

  function automatic logic [31:0] ew(int n, int k, bit pad);
    logic [31:0] w = '0;
    for (int j = 0; j < 4; j++)
      if (!pad || 4 * k + j < n) w[8*j +: 8] = bv(n, 4 * k + j);
    return w;
  endfunction

  function automatic bit vpat(int p, int c);
    return (p == 0) ? 1'b1 : (p == 1) ? (c % 2 == 0) : (c % 3 != 0);
  endfunction

  function automatic bit spat(int p, int c);
    return (p == 0) ? 1'b0 : (p == 1) ? (c % 4 < 2) : (c % 5 == 0);
  endfunction

  task automatic do_start(int n, bit rd);
    @(negedge clk);
    start_i = 1'b1; len_i = 12'(n); dir_rd_i = rd;
    @(posedge clk); #1;
    start_i = 1'b0;
  endtask

  task automatic run_wr(int n, int vp, int fp);
    int words = 0, acc = 0, dones = 0, cyc = 0, bad = 0, tail = 0;
    bit fin = 0;
    do_start(n, 1'b0);
    while (!fin) begin
      @(negedge clk);
      in_valid_i = (acc < n) && vpat(vp, cyc);
      in_data_i = bv(n, acc);
      fifo_full_i = spat(fp, cyc);
      fifo_empty_i = 1'b0;
      dir_rd_i = cyc[0];   // R9: toggling must not matter
      #1;
      if (push_o) begin
        chk(push_data_o == ew(n, words, 1'b1), "R2 R4", "word data", push_data_o, ew(n, words, 1'b1));
        if (fifo_full_i) bad++;
        words++;
      end
      if (in_valid_i && in_ready_o) acc++;
      if (pop_o || out_valid_o) bad++;
      if (done_o) dones++;
      if (dones > 0) tail++;
      if (tail >= 3) fin = 1;
      cyc++;
      if (cyc > 600) begin chk(0, "R7", "write watchdog", cyc, 0); fin = 1; end
    end
    in_valid_i = 1'b0;
    chk(words == (n + 3) / 4, "R4", "word count", words, (n + 3) / 4);
    chk(acc == n, "R3", "bytes accepted", acc, n);
    chk(dones == 1, "R7", "done pulses", dones, 1);
    chk(bad == 0, "R10", "read side moved or full push", bad, 0);
  endtask

  task automatic run_rd(int n, int rp, int ep);
    logic [31:0] fm [8];
    int head = 0, tot = (n + 3) / 4 + 1, got = 0, dones = 0, cyc = 0, bad = 0, tail = 0;
    bit fin = 0;
    for (int k = 0; k < 8; k++) fm[k] = ew(n, k, 1'b0);
    do_start(n, 1'b1);
    while (!fin) begin
      @(negedge clk);
      out_ready_i = vpat(rp, cyc);
      fifo_empty_i = spat(ep, cyc) || head >= tot;
      pop_data_i = (head < tot) ? fm[head] : 32'hdead_beef;
      dir_rd_i = ~cyc[0];  // R9: toggling must not matter
      #1;
      if (out_valid_o && out_ready_i) begin
        chk(out_data_o == bv(n, got), "R5", "byte order", out_data_o, bv(n, got));
        got++;
      end
      if (pop_o) head++;
      if (push_o || in_ready_o) bad++;
      if (done_o) dones++;
      if (dones > 0) tail++;
      if (tail >= 3) fin = 1;
      cyc++;
      if (cyc > 600) begin chk(0, "R7", "read watchdog", cyc, 0); fin = 1; end
    end
    out_ready_i = 1'b0;
    chk(got == n, "R6", "bytes emitted", got, n);
    chk(head == tot - 1, "R6", "words popped", head, tot - 1);
    chk(dones == 1, "R7", "done pulses", dones, 1);
    chk(bad == 0, "R10", "write side moved", bad, 0);
  endtask

  initial begin
    #1_200_000;
    if (!ended) begin
      ended = 1;
      chk(0, "R7", "global watchdog", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start_i = 0; dir_rd_i = 0; len_i = '0; in_valid_i = 1'b1;
    in_data_i = 8'h5a; out_ready_i = 1'b1; fifo_full_i = 0; fifo_empty_i = 0;
    pop_data_i = 32'h1234_5678;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    // R1
    chk({in_ready_o, out_valid_o, push_o, pop_o, done_o} == 5'b0, "R1", "idle outputs",
        {in_ready_o, out_valid_o, push_o, pop_o, done_o}, 0);
    in_valid_i = 1'b0;

    for (int n = 0; n < 14; n++)
      for (int a = 0; a < 3; a++)
        for (int b = 0; b < 3; b++) run_wr(n, a, b);

    for (int n = 0; n < 14; n++)
      for (int a = 0; a < 3; a++)
        for (int b = 0; b < 3; b++) run_rd(n, a, b);

    // R8: abandon a write holding a full word plus pending bytes, then restart
    do_start(9, 1'b0);
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      fifo_full_i = 1'b1; in_valid_i = 1'b1; in_data_i = 8'hff;
    end
    in_valid_i = 1'b0;
    run_wr(5, 0, 0);   // R8 words must carry only new bytes

    // R8: abandon a read with lanes still held, then restart
    do_start(9, 1'b1);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      fifo_empty_i = 1'b0; pop_data_i = 32'hffff_ffff; out_ready_i = (c == 2);
    end
    out_ready_i = 1'b0;
    run_rd(6, 0, 0);   // R8 bytes must come from new words only

    // R10: idle, all inputs active
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      in_valid_i = 1'b1; out_ready_i = 1'b1; fifo_full_i = 0; fifo_empty_i = 0;
      #1;
      chk({in_ready_o, out_valid_o, push_o, pop_o} == 4'b0, "R10", "idle no movement",
          {in_ready_o, out_valid_o, push_o, pop_o}, 0);
    end

    if (!ended) begin
      ended = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule